// File: doc/BRIEF.md
# GPIO Pin Input Conditioning and Interrupt Unit

This unit serves a single general-purpose I/O pin. The raw pad input passes through two synchronizer stages in a row. Each stage is set on its own: it can be skipped entirely, it can capture on the falling clock edge, or it can capture on the rising clock edge. The conditioned level then goes to a detector. The detector can stay off, catch a rising, falling or any edge, or track a low or high level. Edge events set a sticky pending bit, and software clears that bit by pulsing a write-one-to-clear strobe. Level events follow the conditioned input directly and are never latched.

The pin interrupt is routed by two enable bits. One bit sends it to a maskable CPU interrupt and the other to a non-maskable one. A wake request is raised only in the two level modes, and only when wake is enabled, so detecting it needs no running clock. The same configuration word also selects how the core's output value and output enable reach the pad. Push-pull passes both through unchanged. Open-drain drives the pad only when the value is low and releases it otherwise.

All pins here are plain control and status signals. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `pin_input_cond`

## Requirements
- R1: After reset the configuration reads back as zero and irq_mask, irq_nmi, wake_req and sts_pending are all 0.
- R2: A write with cfg_we high stores cfg_wdata at the next rising edge, and cfg_rdata then returns it. The word layout is: bits [2:0] interrupt type, bit 3 maskable enable, bit 4 non-maskable enable, bits [6:5] first-stage mode, bits [8:7] second-stage mode, bit 9 open-drain select, bit 10 wake enable.
- R3: The stage mode codes are 0 = pass-through, 1 = capture on the falling clock edge, and 2 or 3 = capture on the rising clock edge. With the pad changed 1 ns after a rising edge, a rising-edge detect shows on the outputs after this many rising edges: both stages bypassed 1, first stage falling only 1, first stage rising only 2, second stage rising only 2, falling then rising 2, rising then rising 3.
- R4: In type 1 a 0-to-1 change of the conditioned input sets sts_pending. The bit stays set after the input returns to 0, and a 1-to-0 change does not set it.
- R5: In type 2 only a 1-to-0 change of the conditioned input sets sts_pending.
- R6: In type 3 both a rising and a falling change of the conditioned input set sts_pending.
- R7: In type 5 the pin interrupt equals the conditioned input, and in type 4 it equals its inverse. Neither level type sets sts_pending.
- R8: Types 0, 6 and 7 keep irq_mask, irq_nmi and wake_req at 0 and never set sts_pending.
- R9: irq_mask equals the pin interrupt ANDed with enable bit 3, and irq_nmi equals it ANDed with enable bit 4.
- R10: A one-cycle pulse on sts_clr clears sts_pending at the next rising edge. If an edge event arrives in the same cycle, the bit stays set.
- R11: With open-drain select 0, pad_oe = out_en and pad_do = out_val. With select 1, pad_do = 0 and pad_oe = out_en AND NOT out_val.
- R12: wake_req = wake enable AND (type 4 or 5) AND the level condition holds. In any other type it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 1 | Raw pad input level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 11 | Configuration word to store |
| cfg_rdata | output | 11 | Current configuration word |
| sts_clr | input | 1 | Write-one-to-clear pulse for the pending bit |
| sts_pending | output | 1 | Sticky edge-event bit |
| out_val | input | 1 | Output value from the core |
| out_en | input | 1 | Output enable from the core |
| pad_oe | output | 1 | Pad driver enable |
| pad_do | output | 1 | Pad driver value |
| irq_mask | output | 1 | Maskable CPU interrupt request |
| irq_nmi | output | 1 | Non-maskable CPU interrupt request |
| wake_req | output | 1 | Light-sleep wake request |

## Verification
The assertions check these rules on every cycle:
- the output driver rules in both driver modes;
- silence in the disabled types;
- that wake is limited to the level types;
- that interrupts go only to enabled outputs;
- that a pending bit holds until a clear;
- that the high-level type follows the pad when both stages are bypassed.

The directed scenarios show what a single-cycle property cannot. These are the edge polarity each type responds to, the exact latency each stage-mode combination adds, and that clearing works and a later edge sets the bit again.

// File: rtl/pin_cond_pkg.sv
package pin_cond_pkg;
  localparam int CFG_W   = 11;
  localparam int NSTAGE  = 2;
  localparam int TYPE_W  = 3;
  localparam int MODE_W  = 2;

  localparam logic [TYPE_W-1:0] IT_OFF  = 3'd0;
  localparam logic [TYPE_W-1:0] IT_RISE = 3'd1;
  localparam logic [TYPE_W-1:0] IT_FALL = 3'd2;
  localparam logic [TYPE_W-1:0] IT_ANY  = 3'd3;
  localparam logic [TYPE_W-1:0] IT_LOW  = 3'd4;
  localparam logic [TYPE_W-1:0] IT_HIGH = 3'd5;

  localparam logic [MODE_W-1:0] SM_PASS = 2'd0;
  localparam logic [MODE_W-1:0] SM_NEG  = 2'd1;

  typedef struct packed {
    logic              wake_en;
    logic              open_drain;
    logic [MODE_W-1:0] stage2;
    logic [MODE_W-1:0] stage1;
    logic [1:0]        irq_en;
    logic [TYPE_W-1:0] irq_type;
  } pin_cfg_t;
endpackage

// File: rtl/pin_sync_stage.sv
module pin_sync_stage
  import pin_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              d,
  output logic              q
);
  logic q_rise;
  logic q_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_rise <= 1'b0;
    else        q_rise <= d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_fall <= 1'b0;
    else        q_fall <= d;
  end

  always_comb begin
    case (mode)
      SM_PASS: q = d;
      SM_NEG:  q = q_fall;
      default: q = q_rise;
    endcase
  end
endmodule

// File: rtl/pin_edge_level_det.sv
module pin_edge_level_det
  import pin_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cin,
  input  logic [TYPE_W-1:0] irq_type,
  input  logic              clr,
  output logic              pin_int,
  output logic              pending,
  output logic              level_hit
);
  logic prev;
  logic rise;
  logic fall;
  logic edge_hit;
  logic is_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= cin;
  end

  assign rise = cin & ~prev;
  assign fall = ~cin & prev;

  always_comb begin
    edge_hit  = 1'b0;
    level_hit = 1'b0;
    is_edge   = 1'b0;
    case (irq_type)
      IT_RISE: begin is_edge = 1'b1; edge_hit = rise;        end
      IT_FALL: begin is_edge = 1'b1; edge_hit = fall;        end
      IT_ANY:  begin is_edge = 1'b1; edge_hit = rise | fall; end
      IT_LOW:  level_hit = ~cin;
      IT_HIGH: level_hit = cin;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending <= 1'b0;
    else if (edge_hit) pending <= 1'b1;
    else if (clr)      pending <= 1'b0;
  end

  assign pin_int = is_edge ? pending : level_hit;
endmodule

// File: rtl/pin_pad_drive.sv
module pin_pad_drive (
  input  logic open_drain,
  input  logic out_val,
  input  logic out_en,
  output logic pad_oe,
  output logic pad_do
);
  always_comb begin
    if (open_drain) begin
      pad_oe = out_en & ~out_val;
      pad_do = 1'b0;
    end else begin
      pad_oe = out_en;
      pad_do = out_val;
    end
  end
endmodule

// File: rtl/pin_input_cond.sv
module pin_input_cond
  import pin_cond_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_in,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             sts_clr,
  output logic             sts_pending,
  input  logic             out_val,
  input  logic             out_en,
  output logic             pad_oe,
  output logic             pad_do,
  output logic             irq_mask,
  output logic             irq_nmi,
  output logic             wake_req
);
  pin_cfg_t                       cfg;
  logic [NSTAGE:0]                chain;
  logic [NSTAGE-1:0][MODE_W-1:0]  modes;
  logic                           pin_int;
  logic                           level_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_we) cfg <= pin_cfg_t'(cfg_wdata);
  end

  assign cfg_rdata = cfg;
  assign modes     = {cfg.stage2, cfg.stage1};
  assign chain[0]  = pad_in;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    pin_sync_stage i_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .mode (modes[g]),
      .d    (chain[g]),
      .q    (chain[g+1])
    );
  end

  pin_edge_level_det i_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .cin      (chain[NSTAGE]),
    .irq_type (cfg.irq_type),
    .clr      (sts_clr),
    .pin_int  (pin_int),
    .pending  (sts_pending),
    .level_hit(level_hit)
  );

  pin_pad_drive i_drv (
    .open_drain(cfg.open_drain),
    .out_val   (out_val),
    .out_en    (out_en),
    .pad_oe    (pad_oe),
    .pad_do    (pad_do)
  );

  assign irq_mask = pin_int & cfg.irq_en[0];
  assign irq_nmi  = pin_int & cfg.irq_en[1];
  assign wake_req = cfg.wake_en & level_hit;
endmodule

// File: rtl/pin_input_cond_chk.sv
module pin_input_cond_chk
  import pin_cond_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pad_in,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             sts_clr,
  input logic             sts_pending,
  input logic             out_val,
  input logic             out_en,
  input logic             pad_oe,
  input logic             pad_do,
  input logic             irq_mask,
  input logic             irq_nmi,
  input logic             wake_req
);
  logic [2:0] ty;
  logic       off_type;
  logic       lvl_type;
  assign ty       = cfg_rdata[2:0];
  assign off_type = (ty == 3'd0) || (ty == 3'd6) || (ty == 3'd7);
  assign lvl_type = (ty == 3'd4) || (ty == 3'd5);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (cfg_rdata == '0 && !irq_mask && !irq_nmi
                                     && !wake_req && !sts_pending);
    end
  end

  assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    off_type |-> (!irq_mask && !irq_nmi && !wake_req));

  assert_wake_level_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (cfg_rdata[10] && lvl_type));

  assert_route_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> cfg_rdata[3]);

  assert_route_nmi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_nmi |-> cfg_rdata[4]);

  assert_od_never_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[9] |-> (!pad_do && !(pad_oe && out_val)));

  assert_pp_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[9] |-> (pad_oe == out_en && pad_do == out_val));

  assert_pending_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_pending && !sts_clr) |=> sts_pending);

  assert_high_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ty == 3'd5 && cfg_rdata[3] && cfg_rdata[8:5] == 4'd0) |-> (irq_mask == pad_in));
endmodule

bind pin_input_cond pin_input_cond_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pad_in     (pad_in),
  .cfg_rdata  (cfg_rdata),
  .sts_clr    (sts_clr),
  .sts_pending(sts_pending),
  .out_val    (out_val),
  .out_en     (out_en),
  .pad_oe     (pad_oe),
  .pad_do     (pad_do),
  .irq_mask   (irq_mask),
  .irq_nmi    (irq_nmi),
  .wake_req   (wake_req)
);

// File: tb/test_pin_input_cond.sv
`timescale 1ns/1ps
module test_pin_input_cond;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pad_in = 1'b0;
  logic        cfg_we = 1'b0;
  logic [10:0] cfg_wdata = '0;
  logic [10:0] cfg_rdata;
  logic        sts_clr = 1'b0;
  logic        sts_pending;
  logic        out_val = 1'b0;
  logic        out_en = 1'b0;
  logic        pad_oe, pad_do, irq_mask, irq_nmi, wake_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_input_cond i_pin_input_cond (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sts_clr(sts_clr),
    .sts_pending(sts_pending), .out_val(out_val), .out_en(out_en),
    .pad_oe(pad_oe), .pad_do(pad_do), .irq_mask(irq_mask),
    .irq_nmi(irq_nmi), .wake_req(wake_req)
  );

  function automatic logic [10:0] mk(input logic [2:0] ty, input logic [1:0] en,
                                     input logic [1:0] s1, input logic [1:0] s2,
                                     input logic od, input logic wk);
    return {wk, od, s2, s1, en, ty};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_cfg(input logic [10:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic clear_pending();
    sts_clr = 1'b1;
    step(1);
    sts_clr = 1'b0;
  endtask

  task automatic setup(input logic [10:0] w);
    pad_in = 1'b0;
    wr_cfg(w);
    step(4);
    clear_pending();
  endtask

  task automatic t_reset();
    chk("R1 cfg", cfg_rdata, 0);
    chk("R1 irq", {irq_mask, irq_nmi, wake_req, sts_pending}, 0);
  endtask

  task automatic t_cfg();
    wr_cfg(11'h5A7);
    chk("R2 readback", cfg_rdata, 11'h5A7);
    wr_cfg(11'h000);
    chk("R2 readback zero", cfg_rdata, 0);
  endtask

  task automatic t_rise();
    setup(mk(3'd1, 2'b01, 2'd0, 2'd0, 1'b0, 1'b0));
    chk("R4 idle", sts_pending, 0);
    pad_in = 1'b1; step(1);
    chk("R4 set", {irq_mask, irq_nmi, sts_pending}, 3'b101);
    pad_in = 1'b0; step(3);
    chk("R4 sticky", irq_mask, 1);
    clear_pending();
    chk("R10 cleared", {irq_mask, sts_pending}, 0);
    pad_in = 1'b1; step(1);
    chk("R10 reset again", sts_pending, 1);
    clear_pending();
    pad_in = 1'b0; step(2);
    chk("R4 fall ignored", {irq_mask, sts_pending}, 0);
  endtask

  task automatic t_collide();
    setup(mk(3'd1, 2'b01, 2'd0, 2'd0, 1'b0, 1'b0));
    pad_in = 1'b1; sts_clr = 1'b1;
    step(1);
    sts_clr = 1'b0;
    chk("R10 set wins", sts_pending, 1);
  endtask

  task automatic t_fall();
    pad_in = 1'b1;
    wr_cfg(mk(3'd2, 2'b10, 2'd0, 2'd0, 1'b0, 1'b0));
    step(3); clear_pending();
    pad_in = 1'b0; step(1);
    chk("R5 fall nmi", {irq_mask, irq_nmi}, 2'b01);
    clear_pending();
    pad_in = 1'b1; step(2);
    chk("R5 rise ignored", sts_pending, 0);
  endtask

  task automatic t_any();
    setup(mk(3'd3, 2'b11, 2'd0, 2'd0, 1'b0, 1'b0));
    pad_in = 1'b1; step(1);
    chk("R6 rise both", {irq_mask, irq_nmi}, 2'b11);
    clear_pending();
    pad_in = 1'b0; step(1);
    chk("R6 fall", sts_pending, 1);
    clear_pending();
  endtask

  task automatic t_level();
    setup(mk(3'd5, 2'b01, 2'd0, 2'd0, 1'b0, 1'b0));
    pad_in = 1'b1; #1;
    chk("R7 high on", irq_mask, 1);
    step(2);
    pad_in = 1'b0; #1;
    chk("R7 high off", irq_mask, 0);
    chk("R7 no latch", sts_pending, 0);
    wr_cfg(mk(3'd4, 2'b10, 2'd0, 2'd0, 1'b0, 1'b0));
    chk("R7 low on", {irq_mask, irq_nmi}, 2'b01);
    pad_in = 1'b1; #1;
    chk("R9 low off", irq_nmi, 0);
  endtask

  task automatic t_lat(input logic [1:0] s1, input logic [1:0] s2, input int n);
    setup(mk(3'd1, 2'b01, s1, s2, 1'b0, 1'b0));
    pad_in = 1'b1;
    if (n > 1) step(n - 1);
    chk($sformatf("R3 early s1=%0d s2=%0d", s1, s2), irq_mask, 0);
    step(1);
    chk($sformatf("R3 seen s1=%0d s2=%0d", s1, s2), irq_mask, 1);
  endtask

  task automatic t_disabled();
    setup(mk(3'd6, 2'b11, 2'd0, 2'd0, 1'b0, 1'b1));
    pad_in = 1'b1; step(2); pad_in = 1'b0; step(2);
    chk("R8 type6", {irq_mask, irq_nmi, wake_req, sts_pending}, 0);
    wr_cfg(mk(3'd7, 2'b11, 2'd0, 2'd0, 1'b0, 1'b1));
    pad_in = 1'b1; step(2);
    chk("R8 type7", {irq_mask, irq_nmi, wake_req, sts_pending}, 0);
    wr_cfg(mk(3'd0, 2'b11, 2'd0, 2'd0, 1'b0, 1'b1));
    pad_in = 1'b0; step(2);
    chk("R8 type0", {irq_mask, irq_nmi, wake_req, sts_pending}, 0);
  endtask

  task automatic t_drive();
    wr_cfg(mk(3'd0, 2'b00, 2'd0, 2'd0, 1'b0, 1'b0));
    out_en = 1'b1; out_val = 1'b1; #1;
    chk("R11 pp high", {pad_oe, pad_do}, 2'b11);
    out_en = 1'b0; #1;
    chk("R11 pp off", {pad_oe, pad_do}, 2'b01);
    wr_cfg(mk(3'd0, 2'b00, 2'd0, 2'd0, 1'b1, 1'b0));
    out_en = 1'b1; out_val = 1'b1; #1;
    chk("R11 od release", {pad_oe, pad_do}, 2'b00);
    out_val = 1'b0; #1;
    chk("R11 od low", {pad_oe, pad_do}, 2'b10);
    out_en = 1'b0; #1;
  endtask

  task automatic t_wake();
    setup(mk(3'd4, 2'b00, 2'd0, 2'd0, 1'b0, 1'b1));
    chk("R12 low wake", wake_req, 1);
    chk("R12 no irq", {irq_mask, irq_nmi}, 0);
    pad_in = 1'b1; #1;
    chk("R12 wake drop", wake_req, 0);
    wr_cfg(mk(3'd1, 2'b00, 2'd0, 2'd0, 1'b0, 1'b1));
    pad_in = 1'b0; step(2); pad_in = 1'b1; step(2);
    chk("R12 edge no wake", wake_req, 0);
    wr_cfg(mk(3'd5, 2'b00, 2'd0, 2'd0, 1'b0, 1'b0));
    chk("R12 disabled", wake_req, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_cfg();
    t_rise();
    t_collide();
    t_fall();
    t_any();
    t_level();
    t_lat(2'd0, 2'd0, 1);
    t_lat(2'd1, 2'd0, 1);
    t_lat(2'd2, 2'd0, 2);
    t_lat(2'd0, 2'd3, 2);
    t_lat(2'd1, 2'd2, 2);
    t_lat(2'd2, 2'd2, 3);
    t_disabled();
    t_drive();
    t_wake();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule